// File: doc/BRIEF.md
# Product-to-Frequency Converter with Quadrant Modes

This block turns a stream of signed product samples into pulse trains whose average rate follows the product. Each product is the result of multiplying two channel samples upstream. A valid strobe qualifies each sample. On every valid sample a rate word is added to a phase accumulator, and each carry out of the accumulator produces a one-cycle pulse on the fast output. Because the pulse rate follows the running average of the product, a sinusoidal product yields the rate of its mean.

A mode input chooses how the sign of the product is handled. In four-quadrant mode the rate word is the product offset by full scale, so the fast rate sits at a centre frequency FMAX for a zero product. It rises towards 2·FMAX for positive products and falls towards zero for negative ones. In two-quadrant mode only the magnitude counts, so both signs give the same rate k·FMAX. With the default widths, FMAX is one quarter of the valid-sample rate.

A divide-by-N stage counts fast pulses. On every N-th one it emits a fixed-length pulse on one of two slow outputs, alternating between them. This gives a low-rate output pair suited to driving a counter or a display.

Top module: `prod_freq_conv`

## Requirements
- R1: In four-quadrant mode (mode_i = 0) the rate word is p + 2^(PROD_W-1) for product p. After reset, M consecutive valid samples of a constant p give exactly floor(M·(p + 2^(PROD_W-1)) / 2^ACC_W) fast pulses.
- R2: In two-quadrant mode (mode_i = 1) the rate word is |p|. Products p and −p give the same pulse count, floor(M·|p| / 2^ACC_W). The most negative product saturates to magnitude 2^(PROD_W-1) − 1.
- R3: A zero product gives exactly the full-scale count floor(M·2^(PROD_W-1) / 2^ACC_W) in four-quadrant mode, and no fast pulse at all in two-quadrant mode.
- R4: In four-quadrant mode the most negative product gives a rate word of zero and produces no fast pulse.
- R5: A fast pulse is high for exactly one cycle, in the cycle after the clock edge that takes the valid sample whose addition overflows the accumulator. While valid_i is low the accumulator holds its value, prod_i and mode_i have no effect, and no fast pulse is produced.
- R6: Every DIV_N-th fast pulse since reset starts one slow pulse. Slow pulses alternate between slow_a_o (first) and slow_b_o. The slow rate is therefore the fast rate divided by DIV_N and scales with k; for example k = 0.4224 gives 0.4224 of the full-scale slow rate.
- R7: A slow pulse rises in the cycle after the fast pulse that completes the count and stays high for PULSE_LEN cycles. slow_a_o and slow_b_o are never high together.
- R8: Samples that follow a squared sinusoid, with peak at the full-scale magnitude, give a pulse count of floor(sum of rate words / 2^ACC_W). That count is half the constant full-scale count for the same number of samples, within two pulses.
- R9: While rst_i is high, and in the cycle after it is sampled high, all outputs are low. Reset clears both the accumulator and the divide-by-N count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Qualifies prod_i and mode_i for this cycle |
| prod_i | input | PROD_W | Signed product sample, two's complement |
| mode_i | input | 1 | 0 = four-quadrant (offset), 1 = two-quadrant (magnitude) |
| fast_o | output | 1 | One-cycle pulse per accumulator overflow |
| slow_a_o | output | 1 | Slow pulse output, odd-numbered slow pulses |
| slow_b_o | output | 1 | Slow pulse output, even-numbered slow pulses |

## Verification
The assertions rely on three assumptions about the inputs. Reset is held for at least one clock edge. prod_i and mode_i are only meaningful when valid_i is high. Fast pulses are spaced so that one slow pulse ends before the next one starts, which the parameter check PULSE_LEN < DIV_N guarantees. The stimulus changes inputs only on the falling edge and resets before every scenario, so expected counts start from an empty accumulator and divider. It uses products well inside the signed range apart from the deliberate extreme values. The sinusoidal case uses a four-sample squared-sine pattern whose values are exact integers.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic {
      MODE_FOURQ = 1'b0,
      MODE_TWOQ  = 1'b1
   } quad_mode_e;
endpackage

// File: rtl/pfc_rate_sel.sv
// Maps a signed product onto the unsigned rate word for the chosen mode.
module pfc_rate_sel #(
   parameter int PROD_W = 16
) (
   input  logic signed [PROD_W-1:0] prod_i,
   input  pfc_pkg::quad_mode_e      mode_i,
   output logic        [PROD_W-1:0] rate_o
);
   localparam logic [PROD_W-1:0] ONE     = {{(PROD_W-1){1'b0}}, 1'b1};
   localparam logic [PROD_W-1:0] MAG_MAX = {1'b0, {(PROD_W-1){1'b1}}};

   logic [PROD_W-1:0] prod_u;
   logic [PROD_W-1:0] offset_w;
   logic [PROD_W-1:0] negated;
   logic [PROD_W-1:0] mag_w;

   always_comb begin
      prod_u   = prod_i;
      // p + full scale equals p with its sign bit inverted
      offset_w = {~prod_u[PROD_W-1], prod_u[PROD_W-2:0]};
      negated  = (~prod_u) + ONE;
      if (!prod_u[PROD_W-1])
         mag_w = prod_u;
      else if (negated[PROD_W-1])
         mag_w = MAG_MAX;   // most negative value saturates
      else
         mag_w = negated;
      rate_o = (mode_i == pfc_pkg::MODE_TWOQ) ? mag_w : offset_w;
   end
endmodule

// File: rtl/pfc_phase_acc.sv
// Phase accumulator: one pulse per carry out.
module pfc_phase_acc #(
   parameter int RATE_W = 16,
   parameter int ACC_W  = 17
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              valid_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              pulse_o
);
   localparam int PAD = ACC_W + 1 - RATE_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   always_comb sum = {1'b0, acc_q} + {{PAD{1'b0}}, rate_i};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= valid_i & sum[ACC_W];
         if (valid_i) acc_q <= sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/pfc_slow_div.sv
// Divide-by-N of the fast stream onto two alternating fixed-length outputs.
module pfc_slow_div #(
   parameter int DIV_N     = 4,
   parameter int PULSE_LEN = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   output logic slow_a_o,
   output logic slow_b_o
);
   localparam int              DIV_W = $clog2(DIV_N);
   localparam logic [DIV_W-1:0] LAST  = DIV_W'(DIV_N - 1);
   localparam logic [DIV_W-1:0] D_ONE = DIV_W'(1);

   logic [DIV_W-1:0] div_q;
   logic             side_q;
   logic             fire;

   always_comb fire = tick_i && (div_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         div_q  <= '0;
         side_q <= 1'b0;
      end else if (tick_i) begin
         div_q <= fire ? '0 : div_q + D_ONE;
         if (fire) side_q <= ~side_q;
      end
   end

   generate
      if (PULSE_LEN == 1) begin : g_strobe
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               slow_a_o <= 1'b0;
               slow_b_o <= 1'b0;
            end else begin
               slow_a_o <= fire & ~side_q;
               slow_b_o <= fire & side_q;
            end
         end
      end else begin : g_stretch
         localparam int              LEN_W = $clog2(PULSE_LEN);
         localparam logic [LEN_W-1:0] L_INIT = LEN_W'(PULSE_LEN - 1);
         localparam logic [LEN_W-1:0] L_ONE  = LEN_W'(1);
         logic [LEN_W-1:0] len_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               slow_a_o <= 1'b0;
               slow_b_o <= 1'b0;
               len_q    <= '0;
            end else if (fire) begin
               slow_a_o <= ~side_q;
               slow_b_o <= side_q;
               len_q    <= L_INIT;
            end else if (len_q != '0) begin
               len_q <= len_q - L_ONE;
            end else begin
               slow_a_o <= 1'b0;
               slow_b_o <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/prod_freq_conv.sv
// Product-to-frequency converter, top level.
module prod_freq_conv #(
   parameter int PROD_W    = 16,
   parameter int ACC_W     = 17,
   parameter int DIV_N     = 4,
   parameter int PULSE_LEN = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     valid_i,
   input  logic signed [PROD_W-1:0] prod_i,
   input  logic                     mode_i,
   output logic                     fast_o,
   output logic                     slow_a_o,
   output logic                     slow_b_o
);
   generate
      if (PROD_W < 2) begin : g_bad_prod
         $error("PROD_W must be at least 2");
      end
      if (ACC_W <= PROD_W) begin : g_bad_acc
         $error("ACC_W must exceed PROD_W");
      end
      if (DIV_N < 2) begin : g_bad_div
         $error("DIV_N must be at least 2");
      end
      if (PULSE_LEN < 1 || PULSE_LEN >= DIV_N) begin : g_bad_len
         $error("PULSE_LEN must lie in 1 .. DIV_N-1");
      end
   endgenerate

   logic [PROD_W-1:0] rate_w;

   pfc_rate_sel #(.PROD_W(PROD_W)) u_rate (
      .prod_i (prod_i),
      .mode_i (pfc_pkg::quad_mode_e'(mode_i)),
      .rate_o (rate_w)
   );

   pfc_phase_acc #(.RATE_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .valid_i (valid_i),
      .rate_i  (rate_w),
      .pulse_o (fast_o)
   );

   pfc_slow_div #(.DIV_N(DIV_N), .PULSE_LEN(PULSE_LEN)) u_div (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .tick_i   (fast_o),
      .slow_a_o (slow_a_o),
      .slow_b_o (slow_b_o)
   );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int PROD_W = 16
) (
   input logic                     clk_i,
   input logic                     rst_i,
   input logic                     valid_i,
   input logic signed [PROD_W-1:0] prod_i,
   input logic                     mode_i,
   input logic                     fast_o,
   input logic                     slow_a_o,
   input logic                     slow_b_o
);
   localparam logic signed [PROD_W-1:0] PMIN = {1'b1, {(PROD_W-1){1'b0}}};

   logic rst_q = 1'b0;
   always_ff @(posedge clk_i) rst_q <= rst_i;

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      rst_q |-> (!fast_o && !slow_a_o && !slow_b_o)); // R9

   AST_NO_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(valid_i) |-> !fast_o); // R5

   AST_TWOQ_ZERO_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(valid_i && mode_i && prod_i == '0) |-> !fast_o); // R3

   AST_FOURQ_MIN_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(valid_i && !mode_i && prod_i == PMIN) |-> !fast_o); // R4

   AST_SLOW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
      !(slow_a_o && slow_b_o)); // R7

   AST_SLOW_A_AFTER_FAST: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(slow_a_o) |-> $past(fast_o)); // R6

   AST_SLOW_B_AFTER_FAST: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(slow_b_o) |-> $past(fast_o)); // R6
endmodule

bind prod_freq_conv pfc_checker #(.PROD_W(PROD_W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .valid_i  (valid_i),
   .prod_i   (prod_i),
   .mode_i   (mode_i),
   .fast_o   (fast_o),
   .slow_a_o (slow_a_o),
   .slow_b_o (slow_b_o)
);

// File: tb/prod_freq_conv_tb_top.sv
`timescale 1ns/1ps
module prod_freq_conv_tb_top;
   localparam int PROD_W    = 16;
   localparam int ACC_W     = 17;
   localparam int DIV_N     = 4;
   localparam int PULSE_LEN = 2;
   localparam longint FS    = longint'(1) << (PROD_W-1);
   localparam longint WRAP  = longint'(1) << ACC_W;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic valid = 1'b0;
   logic signed [PROD_W-1:0] prod = '0;
   logic mode = 1'b0;
   logic fast, slow_a, slow_b;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   prod_freq_conv #(.PROD_W(PROD_W), .ACC_W(ACC_W), .DIV_N(DIV_N),
                    .PULSE_LEN(PULSE_LEN)) dut_i (
      .clk_i(clk), .rst_i(rst), .valid_i(valid), .prod_i(prod),
      .mode_i(mode), .fast_o(fast), .slow_a_o(slow_a), .slow_b_o(slow_b));

   // monitor
   int  n_fast = 0, n_rise_a = 0, n_rise_b = 0, run_a = 0, last_w_a = 0, both_seen = 0;
   bit  prev_a = 0, prev_b = 0;
   always @(negedge clk) begin
      if (fast) n_fast++;
      if (slow_a && !prev_a) n_rise_a++;
      if (slow_b && !prev_b) n_rise_b++;
      if (slow_a) run_a++;
      else if (prev_a) begin last_w_a = run_a; run_a = 0; end
      if (slow_a && slow_b) both_seen++;
      prev_a = slow_a;
      prev_b = slow_b;
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint rate_of(input bit two, input longint p);
      longint m;
      if (!two) return p + FS;
      m = (p < 0) ? -p : p;
      if (m > FS - 1) m = FS - 1;
      return m;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Streams M samples; sine selects the squared-sine pattern scaled by sgn.
   task automatic run_stream(input string tag, input bit two, input longint p_const,
                             input bit sine, input longint sgn, input int M,
                             output longint got_fast);
      longint sum = 0, p, ef, es;
      int f0, a0, b0;
      longint pat[4] = '{0, 16384, 32767, 16384};
      do_reset();
      f0 = n_fast; a0 = n_rise_a; b0 = n_rise_b;
      for (int i = 0; i < M; i++) begin
         @(negedge clk);
         p = sine ? sgn * pat[i % 4] : p_const;
         valid = 1'b1; mode = two; prod = PROD_W'(p);
         sum += rate_of(two, p);
      end
      @(negedge clk);
      valid = 1'b0;
      repeat (PULSE_LEN + 4) @(negedge clk);
      ef = sum / WRAP;
      es = ef / DIV_N;
      got_fast = n_fast - f0;
      check({tag, " fast count"}, got_fast, ef);
      check({"R6 ", tag, " slow_a count"}, n_rise_a - a0, (es + 1) / 2);
      check({"R6 ", tag, " slow_b count"}, n_rise_b - b0, es / 2);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; valid = 1'b1; prod = 16'sd20000; mode = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 outputs low in reset", {fast, slow_a, slow_b}, 0);
      valid = 1'b0;
      rst = 1'b0;
   endtask

   task automatic t_hold();
      do_reset();
      @(negedge clk); valid = 1'b1; mode = 1'b0; prod = '0;   // acc = FS
      @(negedge clk); valid = 1'b0; prod = 16'sd32767; mode = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (fast) begin
            check("R5 no pulse while valid low", 1, 0);
            break;
         end
      end
      check("R5 idle window quiet", fast, 0);
      mode = 1'b0; prod = '0;
      for (int i = 0; i < 3; i++) begin
         valid = 1'b1;
         @(negedge clk);
         if (i < 2) check("R5 no early carry", fast, 0);
      end
      check("R5 pulse after overflowing sample", fast, 1);
      valid = 1'b0;
      @(negedge clk);
      check("R5 pulse lasts one cycle", fast, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      longint a, b, fs_cnt, k_cnt, sine_cnt, tmp;
      t_reset();
      run_stream("R1 fourq +10000", 0, 10000, 0, 0, 4096, tmp);
      run_stream("R1 fourq -10000", 0, -10000, 0, 0, 4096, tmp);
      run_stream("R1 fourq max", 0, 32767, 0, 0, 4096, tmp);
      run_stream("R2 twoq +10000", 1, 10000, 0, 0, 4096, a);
      run_stream("R2 twoq -10000", 1, -10000, 0, 0, 4096, b);
      check("R2 sign independent", a, b);
      run_stream("R2 twoq min saturates", 1, -32768, 0, 0, 4096, a);
      run_stream("R2 twoq max", 1, 32767, 0, 0, 4096, fs_cnt);
      check("R2 min equals max magnitude", a, fs_cnt);
      run_stream("R3 fourq zero", 0, 0, 0, 0, 1000, tmp);
      check("R3 fourq zero at FMAX", tmp, 250);
      run_stream("R3 twoq zero", 1, 0, 0, 0, 1000, tmp);
      check("R3 twoq zero silent", tmp, 0);
      run_stream("R4 fourq min", 0, -32768, 0, 0, 1000, tmp);
      check("R4 fourq min silent", tmp, 0);
      t_hold();
      run_stream("R6 twoq k=0.4224", 1, 13841, 0, 0, 4096, k_cnt);
      check("R6 k ratio x100", (k_cnt * 100 + fs_cnt / 2) / fs_cnt, 42);
      check("R7 slow pulse width", last_w_a, PULSE_LEN);
      check("R7 slow outputs exclusive", both_seen, 0);
      run_stream("R8 twoq sine", 1, 0, 1, 1, 4096, sine_cnt);
      tmp = 2 * sine_cnt - fs_cnt;
      if (tmp < 0) tmp = -tmp;
      check("R8 sine half of DC full scale", tmp <= 2, 1);
      run_stream("R8 fourq negative sine", 0, 0, 1, -1, 4096, tmp);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule